// File: doc/BRIEF.md
# Switch Input Self-Address and Stall Discard Filter

This block sits at one input of a packet switch and decides, once per packet, whether the packet goes on to the switch fabric or is thrown away. It receives the routing result for the packet at the head of the input queue: the routing mode, the port the packet came in on, and either the chosen output port or a destination bitmap. A packet is dropped when it would leave through its own input port while self-addressing is disabled. It is also dropped when an output it needs has its timeout timer enabled, is not in run state, and does not reach run state before the timer expires.

The filter then either passes characters straight through to the fabric, with the fabric's backpressure applied, or drains them at full rate. In both cases it handles the packet up to and including its end marker and then returns to idle for the next header. The self-addressing enable is an internal bit. An external input sets its value at reset, and a one-cycle write strobe changes it afterwards.

Characters are 9 bits wide. Bit 8 set with low byte 0x00 marks a normal end of packet, and bit 8 set with low byte 0x01 marks an error end. Any other value counts as an ordinary character.

Top module: `selfaddr_filter`

## Requirements
- R1: While `rst` is high, and on the cycle after it, both verdict outputs are low and `in_ready` is low. The self-addressing enable is loaded from `sa_en_init` at reset.
- R2: Routing mode encoding is 00 single, 01 group adaptive, 10 distribution, and 11 is handled as single. In single mode, a header whose `out_port` equals `src_port` is dropped with reason 01 (self) when the enable is 0, and is forwarded when the enable is 1.
- R3: In group adaptive mode, `out_port` carries the port that was actually chosen. The packet is dropped for self-addressing only when that chosen port equals `src_port`; any other chosen port forwards.
- R4: In distribution mode, with the enable at 0, the packet is dropped with reason 01 whenever bit `src_port` of `dest_map` is set, whatever the other bits are. A bitmap without that bit forwards.
- R5: The verdict appears on the clock edge that accepts the header (one cycle after `hdr_valid`), unless the packet must wait under R6. Only one verdict output is high at a time, and it holds until the end marker is consumed. After that the block is idle with `in_ready` low.
- R6: Suppose an output the packet needs (the selected port, or each bitmap port in distribution mode) has `timer_en` set and `link_run` clear at header time. The block then waits, starting a count at header acceptance. If any such port is still not running after `timeout_limit`+1 waiting cycles, the packet is dropped with reason 10 (timeout).
- R7: If every timer-enabled needed port reaches run state during the wait, the packet is forwarded on the next edge. No drop happens.
- R8: A needed port whose `timer_en` is clear never causes a wait. The verdict is immediate even when its link is down.
- R9: While dropping, `in_ready` is high, `out_valid` is low, and `drop_strobe` pulses for every character. The drop ends after either kind of end marker.
- R10: While forwarding, characters pass unchanged and in order. `in_ready` follows `out_ready`, and the end marker is passed on before the block goes idle.
- R11: Changing `sa_en_init` outside reset has no effect. A `sa_wr` pulse loads `sa_wr_val` into the enable.
- R12: A self-addressing drop takes priority over the stall check: it is immediate, with reason 01, even when the needed link is down with its timer enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sa_en_init | input | 1 | Value loaded into the self-addressing enable at reset |
| sa_wr | input | 1 | One-cycle strobe that writes the enable |
| sa_wr_val | input | 1 | New enable value |
| hdr_valid | input | 1 | Routing result valid for the packet at the head of the input |
| route_mode | input | 2 | 00 single, 01 group adaptive, 10 distribution, 11 as single |
| src_port | input | $clog2(NPORTS) | Port the packet arrived on |
| out_port | input | $clog2(NPORTS) | Selected output port (single/adaptive) |
| dest_map | input | NPORTS | Destination bitmap (distribution) |
| link_run | input | NPORTS | Per-output link in run state |
| timer_en | input | NPORTS | Per-output timeout enable |
| timeout_limit | input | TMR_W | Wait limit in cycles |
| in_valid | input | 1 | Input character valid |
| in_data | input | 9 | Input character |
| in_ready | output | 1 | Input character taken |
| out_valid | output | 1 | Character offered to the fabric |
| out_data | output | 9 | Character to the fabric |
| out_ready | input | 1 | Fabric accepts the character |
| verdict_fwd | output | 1 | Current packet is being forwarded |
| verdict_drop | output | 1 | Current packet is being discarded |
| drop_reason | output | 2 | 01 self-address, 10 timeout, 00 otherwise |
| drop_strobe | output | 1 | A character is being thrown away this cycle |

## Verification
The properties assume that `hdr_valid` is raised only while the block is idle and that the first character of the packet is already waiting at the input. They also assume that `timeout_limit` stays constant while a packet waits, and that each packet closes with one of the two end markers. The stimulus keeps to these rules by issuing a header only after the previous packet's end marker has been taken. It changes the limit only between packets, and every packet it builds ends in a marker. Link state, by contrast, is changed freely during a wait, because it is an asynchronous event from the fabric's point of view.

// File: rtl/sf_pkg.sv
package sf_pkg;

  typedef enum logic [1:0] {
    RM_SINGLE = 2'b00,
    RM_ADAPT  = 2'b01,
    RM_DIST   = 2'b10,
    RM_RSVD   = 2'b11
  } route_mode_e;

  typedef enum logic [1:0] {
    DR_NONE    = 2'b00,
    DR_SELF    = 2'b01,
    DR_TIMEOUT = 2'b10
  } drop_rsn_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_WAIT = 2'b01,
    ST_FWD  = 2'b10,
    ST_DROP = 2'b11
  } flt_state_e;

  localparam int CHAR_W = 9;

  // End marker: control flag set and low byte 0x00 (normal) or 0x01 (error)
  function automatic logic is_end_mark(input logic [CHAR_W-1:0] c);
    return c[CHAR_W-1] && (c[CHAR_W-2:1] == '0);
  endfunction

endpackage

// File: rtl/sf_self_chk.sv
module sf_self_chk
  import sf_pkg::*;
#(
  parameter int NPORTS = 8,
  localparam int PW = $clog2(NPORTS)
) (
  input  logic [1:0]        mode,
  input  logic [PW-1:0]     src_port,
  input  logic [PW-1:0]     sel_port,
  input  logic [NPORTS-1:0] dest_map,
  input  logic              sa_en,
  output logic [NPORTS-1:0] need_map,
  output logic              self_hit
);

  logic [NPORTS-1:0] sel_hot;
  logic [NPORTS-1:0] src_hot;

  for (genvar g = 0; g < NPORTS; g++) begin : g_dec
    assign sel_hot[g] = (sel_port == PW'(g));
    assign src_hot[g] = (src_port == PW'(g));
  end

  // Distribution uses the whole list; the other modes use the one chosen port
  always_comb begin
    if (mode == RM_DIST) need_map = dest_map;
    else                 need_map = sel_hot;
  end

  assign self_hit = !sa_en && (|(need_map & src_hot));

endmodule

// File: rtl/sf_stall_timer.sv
module sf_stall_timer #(
  parameter int NPORTS = 8,
  parameter int TMR_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              active,
  input  logic [NPORTS-1:0] mask_in,
  input  logic [NPORTS-1:0] link_run,
  input  logic [TMR_W-1:0]  limit,
  output logic              all_run,
  output logic              expired
);

  logic [NPORTS-1:0] mask_q;
  logic [TMR_W-1:0]  cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      cnt_q  <= '0;
    end else if (start) begin
      mask_q <= mask_in;
      cnt_q  <= '0;
    end else if (active && !expired) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign all_run = ~|(mask_q & ~link_run);
  assign expired = (cnt_q == limit);

endmodule

// File: rtl/sf_pkt_fsm.sv
module sf_pkt_fsm
  import sf_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              hdr_valid,
  input  logic              self_hit,
  input  logic              stall_now,
  input  logic              all_run,
  input  logic              expired,
  input  logic              in_valid,
  input  logic [CHAR_W-1:0] in_data,
  input  logic              out_ready,
  output flt_state_e        st_q,
  output drop_rsn_e         rsn_q,
  output logic              start_tmr,
  output logic              in_ready,
  output logic              out_valid
);

  flt_state_e st_d;
  drop_rsn_e  rsn_d;
  logic       mark;

  assign mark = is_end_mark(in_data);

  always_comb begin
    st_d      = st_q;
    rsn_d     = rsn_q;
    start_tmr = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (hdr_valid) begin
          if (self_hit) begin
            st_d  = ST_DROP;
            rsn_d = DR_SELF;
          end else if (stall_now) begin
            st_d      = ST_WAIT;
            start_tmr = 1'b1;
          end else begin
            st_d  = ST_FWD;
            rsn_d = DR_NONE;
          end
        end
      end
      ST_WAIT: begin
        if (all_run) begin
          st_d  = ST_FWD;
          rsn_d = DR_NONE;
        end else if (expired) begin
          st_d  = ST_DROP;
          rsn_d = DR_TIMEOUT;
        end
      end
      ST_FWD: begin
        if (in_valid && out_ready && mark) st_d = ST_IDLE;
      end
      ST_DROP: begin
        if (in_valid && mark) begin
          st_d  = ST_IDLE;
          rsn_d = DR_NONE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      rsn_q <= DR_NONE;
    end else begin
      st_q  <= st_d;
      rsn_q <= rsn_d;
    end
  end

  always_comb begin
    case (st_q)
      ST_FWD:  in_ready = out_ready;
      ST_DROP: in_ready = 1'b1;
      default: in_ready = 1'b0;
    endcase
  end

  assign out_valid = (st_q == ST_FWD) && in_valid;

endmodule

// File: rtl/selfaddr_filter.sv
module selfaddr_filter
  import sf_pkg::*;
#(
  parameter int NPORTS = 8,
  parameter int TMR_W  = 8,
  localparam int PW = $clog2(NPORTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sa_en_init,
  input  logic              sa_wr,
  input  logic              sa_wr_val,
  input  logic              hdr_valid,
  input  logic [1:0]        route_mode,
  input  logic [PW-1:0]     src_port,
  input  logic [PW-1:0]     out_port,
  input  logic [NPORTS-1:0] dest_map,
  input  logic [NPORTS-1:0] link_run,
  input  logic [NPORTS-1:0] timer_en,
  input  logic [TMR_W-1:0]  timeout_limit,
  input  logic              in_valid,
  input  logic [8:0]        in_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic [8:0]        out_data,
  input  logic              out_ready,
  output logic              verdict_fwd,
  output logic              verdict_drop,
  output logic [1:0]        drop_reason,
  output logic              drop_strobe
);

  logic              sa_en_q;
  logic [NPORTS-1:0] need_map;
  logic              self_hit;
  logic              stall_now;
  logic              start_tmr;
  logic              all_run;
  logic              expired;
  logic              waiting;
  logic              idle;
  flt_state_e        st_q;
  drop_rsn_e         rsn_q;

  // Enable bit: reset value from a pin, later changed by the write strobe
  always_ff @(posedge clk) begin
    if (rst)        sa_en_q <= sa_en_init;
    else if (sa_wr) sa_en_q <= sa_wr_val;
  end

  sf_self_chk #(.NPORTS(NPORTS)) self_i (
    .mode     (route_mode),
    .src_port (src_port),
    .sel_port (out_port),
    .dest_map (dest_map),
    .sa_en    (sa_en_q),
    .need_map (need_map),
    .self_hit (self_hit)
  );

  assign stall_now = |(need_map & timer_en & ~link_run);

  sf_stall_timer #(.NPORTS(NPORTS), .TMR_W(TMR_W)) tmr_i (
    .clk      (clk),
    .rst      (rst),
    .start    (start_tmr),
    .active   (waiting),
    .mask_in  (need_map & timer_en),
    .link_run (link_run),
    .limit    (timeout_limit),
    .all_run  (all_run),
    .expired  (expired)
  );

  sf_pkt_fsm fsm_i (
    .clk       (clk),
    .rst       (rst),
    .hdr_valid (hdr_valid),
    .self_hit  (self_hit),
    .stall_now (stall_now),
    .all_run   (all_run),
    .expired   (expired),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .out_ready (out_ready),
    .st_q      (st_q),
    .rsn_q     (rsn_q),
    .start_tmr (start_tmr),
    .in_ready  (in_ready),
    .out_valid (out_valid)
  );

  assign waiting      = (st_q == ST_WAIT);
  assign idle         = (st_q == ST_IDLE);
  assign verdict_fwd  = (st_q == ST_FWD);
  assign verdict_drop = (st_q == ST_DROP);
  assign drop_reason  = rsn_q;
  assign drop_strobe  = verdict_drop && in_valid;
  assign out_data     = in_data;

endmodule

// File: rtl/sf_chk.sv
module sf_chk #(
  parameter int TMR_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             hdr_valid,
  input logic             in_valid,
  input logic [8:0]       in_data,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic             verdict_fwd,
  input logic             verdict_drop,
  input logic [1:0]       drop_reason,
  input logic             waiting,
  input logic             idle,
  input logic             self_hit,
  input logic [TMR_W-1:0] timeout_limit
);

  logic       mk;
  logic [TMR_W:0] wcnt;

  assign mk = in_data[8] && (in_data[7:1] == 7'd0);

  always_ff @(posedge clk) begin
    if (rst)          wcnt <= '0;
    else if (waiting) wcnt <= wcnt + 1'b1;
    else              wcnt <= '0;
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (!verdict_fwd && !verdict_drop && !in_ready));

  // R5
  one_verdict_chk: assert property (@(posedge clk) disable iff (rst)
    !(verdict_fwd && verdict_drop));

  // R5
  drop_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (verdict_drop && !(in_valid && mk)) |=> verdict_drop);

  // R5
  fwd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (verdict_fwd && !(in_valid && out_ready && mk)) |=> verdict_fwd);

  // R9
  drain_chk: assert property (@(posedge clk) disable iff (rst)
    verdict_drop |-> (in_ready && !out_valid));

  // R10
  backpressure_chk: assert property (@(posedge clk) disable iff (rst)
    (verdict_fwd && !out_ready) |-> !in_ready);

  // R12
  self_first_chk: assert property (@(posedge clk) disable iff (rst)
    (idle && hdr_valid && self_hit) |=> (verdict_drop && drop_reason == 2'b01));

  // R6
  wait_bound_chk: assert property (@(posedge clk) disable iff (rst)
    waiting |-> (wcnt <= {1'b0, timeout_limit}));

endmodule

bind selfaddr_filter sf_chk #(.TMR_W(TMR_W)) chk_i (
  .clk           (clk),
  .rst           (rst),
  .hdr_valid     (hdr_valid),
  .in_valid      (in_valid),
  .in_data       (in_data),
  .in_ready      (in_ready),
  .out_valid     (out_valid),
  .out_ready     (out_ready),
  .verdict_fwd   (verdict_fwd),
  .verdict_drop  (verdict_drop),
  .drop_reason   (drop_reason),
  .waiting       (waiting),
  .idle          (idle),
  .self_hit      (self_hit),
  .timeout_limit (timeout_limit)
);

// File: tb/selfaddr_filter_tb_top.sv
`timescale 1ns/1ps
module selfaddr_filter_tb_top;

  localparam int NP = 8;
  localparam int TW = 8;
  localparam logic [8:0] EOP = 9'h100;
  localparam logic [8:0] EEP = 9'h101;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sa_en_init = 1'b0;
  logic sa_wr = 1'b0;
  logic sa_wr_val = 1'b0;
  logic hdr_valid = 1'b0;
  logic [1:0] route_mode = 2'b00;
  logic [2:0] src_port = '0;
  logic [2:0] out_port = '0;
  logic [NP-1:0] dest_map = '0;
  logic [NP-1:0] link_run = '1;
  logic [NP-1:0] timer_en = '0;
  logic [TW-1:0] timeout_limit = 8'd5;
  logic in_valid = 1'b0;
  logic [8:0] in_data = '0;
  logic in_ready;
  logic out_valid;
  logic [8:0] out_data;
  logic out_ready = 1'b1;
  logic verdict_fwd, verdict_drop;
  logic [1:0] drop_reason;
  logic drop_strobe;

  int n_tests = 0;
  int n_fail = 0;
  bit bp_on = 1'b0;
  int out_cnt = 0;
  int drop_cnt = 0;
  int mon_idx = 0;
  int mon_len = 0;
  logic [8:0] mon_mk = EOP;

  typedef struct {
    bit         drop;
    logic [1:0] rsn;
    string      req;
  } exp_t;
  exp_t exp_q[$];

  always #4 clk = ~clk;

  selfaddr_filter #(.NPORTS(NP), .TMR_W(TW)) dut_i (
    .clk(clk), .rst(rst), .sa_en_init(sa_en_init), .sa_wr(sa_wr), .sa_wr_val(sa_wr_val),
    .hdr_valid(hdr_valid), .route_mode(route_mode), .src_port(src_port), .out_port(out_port),
    .dest_map(dest_map), .link_run(link_run), .timer_en(timer_en), .timeout_limit(timeout_limit),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready), .out_valid(out_valid),
    .out_data(out_data), .out_ready(out_ready), .verdict_fwd(verdict_fwd),
    .verdict_drop(verdict_drop), .drop_reason(drop_reason), .drop_strobe(drop_strobe)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [8:0] pkt_char(input int idx, input int len, input logic [8:0] mk);
    return (idx == len - 1) ? mk : {1'b0, 8'(idx + 16)};
  endfunction

  task automatic finish_tb();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  // backpressure pattern on the fabric side
  initial begin
    forever begin
      @(negedge clk);
      if (bp_on) out_ready = ~out_ready;
      else       out_ready = 1'b1;
    end
  end

  // monitor: scoreboard for verdicts, order and content of passed characters
  initial begin
    logic [1:0] v_prev;
    logic [1:0] v_now;
    v_prev = 2'b00;
    forever begin
      @(negedge clk);
      #3;
      v_now = {verdict_drop, verdict_fwd};
      if (!rst && v_now != 2'b00 && v_prev == 2'b00) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R5", "unexpected verdict", int'(v_now), 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(verdict_drop == e.drop, e.req, "verdict drop", int'(verdict_drop), int'(e.drop));
          chk(drop_reason == e.rsn, e.req, "drop reason", int'(drop_reason), int'(e.rsn));
        end
      end
      if (v_now != 2'b00 && v_prev != 2'b00 && v_now != v_prev)
        chk(1'b0, "R5", "verdict changed inside packet", int'(v_now), int'(v_prev));
      v_prev = v_now;
      if (out_valid && out_ready) begin
        chk(out_data == pkt_char(mon_idx, mon_len, mon_mk), "R10", "forwarded char",
            int'(out_data), int'(pkt_char(mon_idx, mon_len, mon_mk)));
        mon_idx++;
        out_cnt++;
      end
      if (drop_strobe) drop_cnt++;
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "WDOG", "watchdog expired", 1, 0);
    finish_tb();
  end

  task automatic do_reset(input logic init);
    @(negedge clk);
    rst = 1'b1;
    sa_en_init = init;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic write_sa(input logic v);
    @(negedge clk);
    sa_wr = 1'b1;
    sa_wr_val = v;
    @(negedge clk);
    sa_wr = 1'b0;
  endtask

  // Driver: present header, push expectation, check verdict timing, stream packet
  task automatic send_pkt(input logic [1:0] mode, input logic [2:0] src, input logic [2:0] port,
                          input logic [NP-1:0] map, input int len, input logic [8:0] mk,
                          input bit exp_drop, input logic [1:0] exp_rsn, input int exp_wait,
                          input int lnk_after, input string req);
    int o0, d0, j;
    exp_t e;
    e.drop = exp_drop; e.rsn = exp_rsn; e.req = req;
    exp_q.push_back(e);
    @(negedge clk);
    o0 = out_cnt; d0 = drop_cnt;
    mon_idx = 0; mon_len = len; mon_mk = mk;
    route_mode = mode; src_port = src; out_port = port; dest_map = map;
    hdr_valid = 1'b1;
    in_valid = 1'b1;
    in_data = pkt_char(0, len, mk);
    @(negedge clk);
    hdr_valid = 1'b0;
    j = 0;
    while (!(verdict_fwd || verdict_drop)) begin
      if (j == lnk_after) link_run[port] = 1'b1;
      j++;
      @(negedge clk);
    end
    chk(j == exp_wait, req, "verdict delay cycles", j, exp_wait);
    for (int i = 0; i < len; i++) begin
      bit r;
      in_data = pkt_char(i, len, mk);
      in_valid = 1'b1;
      forever begin
        #3;
        r = in_ready;
        @(negedge clk);
        if (r) break;
      end
    end
    in_valid = 1'b0;
    chk(!verdict_fwd && !verdict_drop && !in_ready, "R5", "idle after end marker",
        int'({verdict_fwd, verdict_drop, in_ready}), 0);
    chk(out_cnt - o0 == (exp_drop ? 0 : len), exp_drop ? "R9" : "R10", "chars forwarded",
        out_cnt - o0, exp_drop ? 0 : len);
    chk(drop_cnt - d0 == (exp_drop ? len : 0), exp_drop ? "R9" : "R10", "chars dropped",
        drop_cnt - d0, exp_drop ? len : 0);
  endtask

  initial begin
    // R1: reset state with init value 0
    rst = 1'b1;
    sa_en_init = 1'b0;
    repeat (3) @(negedge clk);
    chk(!verdict_fwd && !verdict_drop && !in_ready && !out_valid, "R1", "outputs in reset",
        int'({verdict_fwd, verdict_drop, in_ready, out_valid}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!verdict_fwd && !verdict_drop && !in_ready, "R1", "idle after reset",
        int'({verdict_fwd, verdict_drop, in_ready}), 0);

    // R2: enable loaded 0 at reset, single self-address dropped
    send_pkt(2'b00, 3'd2, 3'd2, '0, 4, EOP, 1'b1, 2'b01, 0, -1, "R2");
    // R2: single to another port forwarded
    send_pkt(2'b00, 3'd2, 3'd4, '0, 5, EOP, 1'b0, 2'b00, 0, -1, "R2");

    // R11: init pin changed outside reset has no effect
    @(negedge clk);
    sa_en_init = 1'b1;
    send_pkt(2'b00, 3'd1, 3'd1, '0, 3, EOP, 1'b1, 2'b01, 0, -1, "R11");
    // R11: write strobe sets enable, self-address now forwarded
    write_sa(1'b1);
    send_pkt(2'b00, 3'd1, 3'd1, '0, 3, EOP, 1'b0, 2'b00, 0, -1, "R11");
    write_sa(1'b0);

    // R3: adaptive choice equal to source dropped, other choice forwarded
    send_pkt(2'b01, 3'd3, 3'd3, '0, 3, EOP, 1'b1, 2'b01, 0, -1, "R3");
    send_pkt(2'b01, 3'd3, 3'd6, '0, 3, EOP, 1'b0, 2'b00, 0, -1, "R3");

    // R4: distribution containing source dropped (error end), without source forwarded
    send_pkt(2'b10, 3'd0, 3'd7, 8'b0000_0111, 4, EEP, 1'b1, 2'b01, 0, -1, "R4");
    send_pkt(2'b10, 3'd0, 3'd0, 8'b0110_0110, 4, EOP, 1'b0, 2'b00, 0, -1, "R4");

    // R2: reserved mode handled as single
    send_pkt(2'b11, 3'd5, 3'd5, '0, 2, EOP, 1'b1, 2'b01, 0, -1, "R2");

    // R6: link down with timer on, limit 5: waits 6 cycles then timeout drop
    link_run[5] = 1'b0;
    timer_en[5] = 1'b1;
    timeout_limit = 8'd5;
    send_pkt(2'b00, 3'd0, 3'd5, '0, 3, EOP, 1'b1, 2'b10, 6, -1, "R6");

    // R7: link comes up during wait -> forwarded on the next edge
    send_pkt(2'b00, 3'd0, 3'd5, '0, 3, EOP, 1'b0, 2'b00, 3, 2, "R7");
    link_run[5] = 1'b0;

    // R6: limit 0 expires after one waiting cycle
    timeout_limit = 8'd0;
    send_pkt(2'b00, 3'd0, 3'd5, '0, 2, EOP, 1'b1, 2'b10, 1, -1, "R6");
    timeout_limit = 8'd5;

    // R12: self-address takes priority over a stalled link
    send_pkt(2'b00, 3'd5, 3'd5, '0, 2, EOP, 1'b1, 2'b01, 0, -1, "R12");

    // R6: distribution with one stalled timer-enabled port times out
    send_pkt(2'b10, 3'd0, 3'd0, 8'b0010_0110, 3, EEP, 1'b1, 2'b10, 6, -1, "R6");

    // R8: timer disabled, link down -> immediate forward
    timer_en[5] = 1'b0;
    send_pkt(2'b00, 3'd0, 3'd5, '0, 3, EOP, 1'b0, 2'b00, 0, -1, "R8");
    link_run[5] = 1'b1;

    // R10: forwarding under backpressure keeps order and content
    bp_on = 1'b1;
    send_pkt(2'b00, 3'd1, 3'd2, '0, 7, EOP, 1'b0, 2'b00, 0, -1, "R10");
    bp_on = 1'b0;

    // R9: dropping ignores backpressure
    bp_on = 1'b1;
    send_pkt(2'b00, 3'd4, 3'd4, '0, 5, EEP, 1'b1, 2'b01, 0, -1, "R9");
    bp_on = 1'b0;

    // R1: reset with init 1 -> self-address forwarded
    do_reset(1'b1);
    @(negedge clk);
    send_pkt(2'b00, 3'd6, 3'd6, '0, 3, EOP, 1'b0, 2'b00, 0, -1, "R1");

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R5", "all verdicts seen", exp_q.size(), 0);
    finish_tb();
  end

endmodule